// File: doc/BRIEF.md
# Serial ADC Power-Mode Tracker

This block sits on the device side of a serial converter bus. It watches the active-low chip select and the serial clock, and from them it keeps track of the converter's power state. That state is one of normal, partial power-down, full power-down, or powering-up. Inside every chip-select-low frame it counts the falling edges of the serial clock. When chip select rises, the count sorts the frame into one of three classes: too short to matter, aborted inside the power-down window, or complete.

The power state moves only at the end of a frame, with one exception. The wake timer runs from full power-down and can finish in the middle of idle time. A frame aborted in the window steps the device one level deeper into power-down. A complete frame taken while powered down acts as a dummy wake frame. Waking from partial power-down ends with that frame. Waking from full power-down keeps the device in the powering-up state until a parameter-set timer expires. That timer is longer than a frame.

Each frame produces a one-cycle report. The report carries the frame class and a flag that says whether the frame's data counts as a valid conversion. A parameter selects the power state at reset, so that each power-on case can be modelled.

Top module: `adc_pwr_tracker`

## Requirements
- R1: The counter counts serial-clock falling edges seen while chip select is low, starting from zero at each chip-select fall. At chip-select rise, a count of 0 or 1 gives class 0 (short), a count of 2 to 9 gives class 1 (aborted in window), and a count of 10 or more gives class 2 (complete). These values appear on `frame_cls_o`.
- R2: `frame_vld_o` is high for exactly one clock, in the cycle after the clock edge that samples chip select high again. `frame_cls_o` and `data_ok_o` are valid in that same cycle.
- R3: An aborted frame in normal mode (mode code 0) moves `mode_o` to partial power-down (code 1).
- R4: An aborted frame in partial power-down moves the mode to full power-down (code 2). An aborted frame in full power-down leaves it there.
- R5: A short frame leaves the mode unchanged in normal, partial and full power-down.
- R6: A complete frame in partial power-down returns the mode to normal when chip select rises. That frame reports `data_ok_o` low.
- R7: A complete frame in full power-down moves the mode to powering-up (code 3). The mode becomes normal in the cycle that follows the clock edge sampling that frame's chip-select fall by WAKE_CYC+1 edges. Frames taken while powering-up report `data_ok_o` low and do not change the mode. A full power-down frame that does not complete cancels the timer.
- R8: `data_ok_o` is high only for a complete frame that started while the mode was normal.
- R9: After reset the mode equals the INIT_MODE parameter, and `frame_vld_o` is low. `powered_up_o` is high exactly when the mode is normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| mode_o | output | 2 | Power state: 0 normal, 1 partial, 2 full, 3 powering-up |
| powered_up_o | output | 1 | High when the mode is normal |
| frame_vld_o | output | 1 | One-cycle end-of-frame report strobe |
| frame_cls_o | output | 2 | Frame class: 0 short, 1 aborted, 2 complete |
| data_ok_o | output | 1 | The frame held a valid conversion |

## Verification
The assertions take for granted that chip select and the serial clock are already synchronous to `clk_i`. They also assume that each serial-clock level lasts at least one clock, and that no serial-clock fall lands in the same sampled cycle as a chip-select edge. One input assertion flags any violation of that last point. The bench drives both lines on the falling system-clock edge. It inserts two clocks between chip-select changes and serial-clock edges, and it holds every serial-clock level for two clocks, so every edge is sampled alone. The wake frames are kept short enough that each one ends before the wake timer expires.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_PARTIAL = 2'd1,
    MODE_FULL    = 2'd2,
    MODE_WAKING  = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    CLS_SHORT = 2'd0,
    CLS_ABORT = 2'd1,
    CLS_DONE  = 2'd2
  } frame_cls_e;
endpackage

// File: rtl/adc_pwr_edges.sv
module adc_pwr_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sclk_i,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sclk_fall_o
);
  logic cs_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
    end else begin
      cs_q   <= cs_n_i;
      sclk_q <= sclk_i;
    end
  end

  assign cs_fall_o   = cs_q & ~cs_n_i;
  assign cs_rise_o   = ~cs_q & cs_n_i;
  // only edges inside a selected frame are counted
  assign sclk_fall_o = sclk_q & ~sclk_i & ~cs_n_i;

  AST_SCLK_APART_FROM_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_o || cs_rise_o) |-> !(sclk_q && !sclk_i)); // R1
endmodule

// File: rtl/adc_pwr_frame.sv
module adc_pwr_frame
  import adc_pwr_pkg::*;
#(
  parameter int WIN_LO = 2,
  parameter int WIN_HI = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_fall_i,
  input  logic       sclk_fall_i,
  output frame_cls_e cls_o
);
  localparam int CW = $clog2(WIN_HI + 1);
  localparam logic [CW-1:0] LO = CW'(WIN_LO);
  localparam logic [CW-1:0] HI = CW'(WIN_HI);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (cs_fall_i)                  cnt_q <= '0;
    else if (sclk_fall_i && cnt_q != HI) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (cnt_q >= HI)      cls_o = CLS_DONE;
    else if (cnt_q >= LO) cls_o = CLS_ABORT;
    else                  cls_o = CLS_SHORT;
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= HI); // R1
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> cnt_q == '0); // R1
endmodule

// File: rtl/adc_pwr_wake.sv
module adc_pwr_wake #(
  parameter int WAKE_CYC = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  output logic done_o
);
  localparam int TW = $clog2(WAKE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(WAKE_CYC);

  logic [TW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == LAST);

  AST_WAKE_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && !stop_i && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1); // R7
  AST_WAKE_START_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o); // R7
endmodule

// File: rtl/adc_pwr_tracker.sv
module adc_pwr_tracker
  import adc_pwr_pkg::*;
#(
  parameter pwr_mode_e INIT_MODE = MODE_NORMAL,
  parameter int        WIN_LO    = 2,
  parameter int        WIN_HI    = 10,
  parameter int        WAKE_CYC  = 150
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       sclk_i,
  output logic [1:0] mode_o,
  output logic       powered_up_o,
  output logic       frame_vld_o,
  output logic [1:0] frame_cls_o,
  output logic       data_ok_o
);
  logic       cs_fall, cs_rise, sclk_fall, wake_done, wake_start, wake_stop;
  frame_cls_e cls;
  pwr_mode_e  mode_q, mode_d, start_mode_q;

  adc_pwr_edges u_edges (
    .clk_i, .rst_ni, .cs_n_i, .sclk_i,
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .sclk_fall_o(sclk_fall)
  );

  adc_pwr_frame #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_frame (
    .clk_i, .rst_ni, .cs_fall_i(cs_fall), .sclk_fall_i(sclk_fall), .cls_o(cls)
  );

  adc_pwr_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk_i, .rst_ni, .start_i(wake_start), .stop_i(wake_stop), .done_o(wake_done)
  );

  // timer starts on the dummy frame's CS fall, survives only if the frame completes
  assign wake_start = cs_fall && (mode_q == MODE_FULL);
  assign wake_stop  = (cs_rise && mode_q == MODE_FULL && cls != CLS_DONE) ||
                      (mode_q == MODE_WAKING && wake_done);

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_NORMAL:  if (cs_rise && cls == CLS_ABORT) mode_d = MODE_PARTIAL;
      MODE_PARTIAL: if (cs_rise) begin
                      if (cls == CLS_ABORT)     mode_d = MODE_FULL;
                      else if (cls == CLS_DONE) mode_d = MODE_NORMAL;
                    end
      MODE_FULL:    if (cs_rise && cls == CLS_DONE) mode_d = MODE_WAKING;
      MODE_WAKING:  if (wake_done) mode_d = MODE_NORMAL;
      default:      mode_d = mode_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= INIT_MODE;
      start_mode_q <= INIT_MODE;
      frame_vld_o  <= 1'b0;
      frame_cls_o  <= 2'd0;
      data_ok_o    <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      frame_vld_o <= cs_rise;
      if (cs_fall) start_mode_q <= mode_q;
      if (cs_rise) begin
        frame_cls_o <= cls;
        data_ok_o   <= (start_mode_q == MODE_NORMAL) && (cls == CLS_DONE);
      end else begin
        data_ok_o   <= 1'b0;
      end
    end
  end

  assign mode_o       = mode_q;
  assign powered_up_o = (mode_q == MODE_NORMAL);

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |=> !frame_vld_o); // R2
  AST_ABORT_TO_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && cls == CLS_ABORT && mode_q == MODE_NORMAL) |=> mode_o == MODE_PARTIAL); // R3
  AST_ABORT_TO_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && cls == CLS_ABORT && mode_q inside {MODE_PARTIAL, MODE_FULL}) |=> mode_o == MODE_FULL); // R4
  AST_SHORT_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise && cls == CLS_SHORT && mode_q != MODE_WAKING) |=> $stable(mode_o)); // R5
  AST_WAKING_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAKING && !wake_done) |=> mode_o == MODE_WAKING); // R7
  AST_OK_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ok_o |-> (frame_vld_o && frame_cls_o == CLS_DONE)); // R8
endmodule

// File: tb/adc_pwr_tracker_test.sv
module adc_pwr_tracker_test;
  import adc_pwr_pkg::*;

  localparam int WAKE = 150;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [1:0] mode, cls_o, mode_p, mode_f, cls_p, cls_f;
  logic pwr, vld, ok, pwr_p, vld_p, ok_p, pwr_f, vld_f, ok_f;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [1:0] model;
  logic [4:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_pwr_tracker #(.WAKE_CYC(WAKE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mode_o(mode),
    .powered_up_o(pwr), .frame_vld_o(vld), .frame_cls_o(cls_o), .data_ok_o(ok));
  adc_pwr_tracker #(.INIT_MODE(MODE_PARTIAL), .WAKE_CYC(WAKE)) uut_part (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mode_o(mode_p),
    .powered_up_o(pwr_p), .frame_vld_o(vld_p), .frame_cls_o(cls_p), .data_ok_o(ok_p));
  adc_pwr_tracker #(.INIT_MODE(MODE_FULL), .WAKE_CYC(WAKE)) uut_full (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mode_o(mode_f),
    .powered_up_o(pwr_f), .frame_vld_o(vld_f), .frame_cls_o(cls_f), .data_ok_o(ok_f));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one frame with n serial-clock falls; pushes the expected report
  task automatic frame(input int n, output int t_fall);
    logic [1:0] c, nm;
    logic o;
    @(negedge clk);
    cs_n = 1'b0;
    t_fall = cyc;
    c = (n <= 1) ? 2'd0 : (n <= 9) ? 2'd1 : 2'd2;
    o = (model == 2'd0) && (c == 2'd2);
    nm = model;
    case (model)
      2'd0: if (c == 2'd1) nm = 2'd1;
      2'd1: if (c == 2'd1) nm = 2'd2; else if (c == 2'd2) nm = 2'd0;
      2'd2: if (c == 2'd2) nm = 2'd3;
      default: nm = model;
    endcase
    exp_q.push_back({c, o, nm});
    model = nm;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // monitor: compares each frame report against the scoreboard
  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected report", 1, 0);
      end else begin
        logic [4:0] e;
        e = exp_q.pop_front();
        chk("R1 frame class", int'(cls_o), int'(e[4:3]));
        chk("R8 data ok", int'(ok), int'(e[2]));
        chk("R3-mode after frame", int'(mode), int'(e[1:0]));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int t, tw;
    model = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset mode normal", int'(mode), 0);
    chk("R9 reset powered", int'(pwr), 1);
    chk("R9 reset no report", int'(vld), 0);
    chk("R9 reset mode partial", int'(mode_p), 1);
    chk("R9 reset partial not powered", int'(pwr_p), 0);
    chk("R9 reset mode full", int'(mode_f), 2);

    frame(16, t);                 // R8 valid conversion
    chk("R6 partial woken by dummy", int'(mode_p), 0);
    chk("R6 dummy frame not ok", int'(ok_p), 0);
    chk("R7 full enters waking", int'(mode_f), 3);
    frame(1, t);                  // R5 short in normal
    frame(2, t);                  // R3 lower window edge
    chk("R9 partial not powered", int'(pwr), 0);
    frame(0, t);                  // R5 short in partial
    frame(10, t);                 // R6 upper window edge completes
    frame(9, t);                  // R3 last aborting count
    frame(5, t);                  // R4 partial -> full
    frame(3, t);                  // R4 stays full, timer cancelled
    chk("R4 still full", int'(mode), 2);
    frame(16, tw);                // R7 wake frame
    frame(12, t);                 // R7 frame during waking
    wait (cyc == tw + WAKE + 1);
    @(negedge clk);
    chk("R7 still waking", int'(mode), 3);
    @(negedge clk);
    chk("R7 normal after timer", int'(mode), 0);
    chk("R9 powered after wake", int'(pwr), 1);
    model = 2'd0;
    frame(11, t);                 // R8 valid again
    chk("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule